// File: doc/BRIEF.md
# Four-Port GPIO Register Bank

This block holds the software-visible state of four 8-bit general-purpose I/O ports behind a byte-wide synchronous register bus. Each port has a data-out byte, an output-mode byte and a direction byte, all writable, plus a read-only byte that reports the pin levels after synchronization. Two pin-function select bytes are also stored. The data-out and direction bytes drive the pads directly: a direction bit of 1 turns the pin into an output.

An access happens when `req_i` is high in a clock cycle. Read data and the error flag are combinational in that same cycle, and a legal write takes effect on the rising edge that ends it. The bank does not mask illegal accesses. A write that would set an unimplemented bit is refused as a whole. The same applies to a non-byte access, an access to an unmapped offset and any write to a pin byte. A refused access raises `err_o` for that cycle and leaves every register unchanged.

Top module: `gpio_bank`

## Requirements
- R1: The map works as follows. Data-out bytes of ports 0..3 sit at 0x00, 0x01, 0x04, 0x05. Mode bytes sit at 0x20, 0x21, 0x24, 0x25, direction bytes at 0x60, 0x61, 0x64, 0x65 and pin bytes at 0x80, 0x81, 0x84, 0x85. Select byte A is at 0x44 and select byte B at 0x48. A legal read returns the stored byte unchanged.
- R2: After reset every byte reads 0x00, with two exceptions: the port 2 mode byte reads 0xFF and select byte B reads 0x0F.
- R3: An access to any offset outside the map raises `err_o` and changes no register.
- R4: `size_i` encodes 2'b00 as one byte, 2'b01 as two bytes and 2'b10 as four bytes. Any access that is not one byte raises `err_o` and has no effect.
- R5: The port 3 data-out, mode and direction bytes implement bits 1:0 only. A write with any of bits 7:2 set is refused with `err_o`, and the old value is kept.
- R6: The port 0 and port 1 mode bytes implement bit 0 only. A write with any of bits 7:1 set is refused with `err_o`.
- R7: Select byte A refuses writes with bits 7:2 set. Select byte B refuses writes with bits 7:4 set.
- R8: A write to any pin byte raises `err_o`.
- R9: Each pin byte passes through a two-flop synchronizer. A pin change shows in a read after two rising edges, and not after one.
- R10: `out_o[8p+7:8p]` equals the port p data-out byte and `oe_o[8p+7:8p]` equals the port p direction byte.
- R11: `err_o` is high only in a cycle with `req_i` high. An erroring read returns `rdata_o` = 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size: 00 byte, 01 half, 10 word |
| addr_i | input | AW (8) | Byte offset within the bank |
| wdata_i | input | DW (8) | Write data |
| rdata_o | output | DW (8) | Read data, valid in the strobe cycle |
| err_o | output | 1 | Access refused, pulse in the strobe cycle |
| pins_i | input | NPORTS*DW (32) | Asynchronous pin levels, port p at bits 8p+7:8p |
| out_o | output | NPORTS*DW (32) | Output value per pin |
| oe_o | output | NPORTS*DW (32) | Output enable per pin |

## Verification
Some properties are checked on every clock. These are:
- the error flag is tied to the strobe;
- a non-byte access, a pin-byte write and an over-wide port 3 data-out write always error;
- an erroring read returns zero;
- a refused write leaves both pad vectors stable;
- the unimplemented port 3 bits of both vectors stay low.

Other behaviour only the bench scenarios can show. This covers the stored value read back after each legal write and the exact reset contents of all eighteen bytes. It also covers the per-register writable masks at their boundaries (for example 0x03 accepted and 0x04 refused) and the two-edge pin latency.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_OUT,
    RK_MODE,
    RK_DIR,
    RK_PIN,
    RK_SELA,
    RK_SELB
  } reg_kind_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;

  localparam logic [7:0] BASE_OUT  = 8'h00;
  localparam logic [7:0] BASE_MODE = 8'h20;
  localparam logic [7:0] BASE_DIR  = 8'h60;
  localparam logic [7:0] BASE_PIN  = 8'h80;
  localparam logic [7:0] OFF_SELA  = 8'h44;
  localparam logic [7:0] OFF_SELB  = 8'h48;

  localparam logic [7:0] SELA_MASK = 8'h03;
  localparam logic [7:0] SELB_MASK = 8'h0F;
  localparam logic [7:0] SELB_RST  = 8'h0F;

  // ports pair up: 0,1 at +0/+1, 2,3 at +4/+5
  function automatic logic [7:0] port_slot(input int p);
    return 8'(((p >> 1) << 2) | (p & 1));
  endfunction

  function automatic logic [7:0] out_mask(input int p);
    return (p == 3) ? 8'h03 : 8'hFF;
  endfunction

  function automatic logic [7:0] mode_mask(input int p);
    if (p < 2)       return 8'h01;
    else if (p == 2) return 8'hFF;
    else             return 8'h03;
  endfunction

  function automatic logic [7:0] mode_rst(input int p);
    return (p == 2) ? 8'hFF : 8'h00;
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned AW     = 8,
  localparam int unsigned PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic [AW-1:0] addr_i,
  output reg_kind_e     kind_o,
  output logic [PW-1:0] port_o
);

  always_comb begin
    kind_o = RK_NONE;
    port_o = '0;
    if (addr_i == AW'(OFF_SELA)) kind_o = RK_SELA;
    if (addr_i == AW'(OFF_SELB)) kind_o = RK_SELB;
    for (int p = 0; p < int'(NPORTS); p++) begin
      if (addr_i == AW'(BASE_OUT + port_slot(p))) begin
        kind_o = RK_OUT;  port_o = PW'(p);
      end
      if (addr_i == AW'(BASE_MODE + port_slot(p))) begin
        kind_o = RK_MODE; port_o = PW'(p);
      end
      if (addr_i == AW'(BASE_DIR + port_slot(p))) begin
        kind_o = RK_DIR;  port_o = PW'(p);
      end
      if (addr_i == AW'(BASE_PIN + port_slot(p))) begin
        kind_o = RK_PIN;  port_o = PW'(p);
      end
    end
  end

endmodule

// File: rtl/gpio_byte_reg.sv
module gpio_byte_reg #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST    = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (we_i) q_o <= d_i;
  end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [1:0]         size_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               err_o,
  input  logic [NPORTS*DW-1:0] pins_i,
  output logic [NPORTS*DW-1:0] out_o,
  output logic [NPORTS*DW-1:0] oe_o
);

  localparam int unsigned PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  reg_kind_e     kind;
  logic [PW-1:0] port;

  logic [DW-1:0] out_q  [NPORTS];
  logic [DW-1:0] mode_q [NPORTS];
  logic [DW-1:0] dir_q  [NPORTS];
  logic [DW-1:0] pin_q  [NPORTS];
  logic [DW-1:0] sela_q, selb_q;

  logic [DW-1:0] wmask;
  logic [DW-1:0] rval;
  logic          mapped;
  logic          wr_ok;
  logic          commit;

  gpio_addr_decode #(.NPORTS(NPORTS), .AW(AW)) u_dec (
    .addr_i (addr_i),
    .kind_o (kind),
    .port_o (port)
  );

  assign mapped = (kind != RK_NONE) && (size_i == SZ_BYTE);

  always_comb begin
    wmask = '0;
    rval  = '0;
    unique case (kind)
      RK_OUT:  begin wmask = DW'(out_mask(int'(port)));  rval = out_q[port];  end
      RK_MODE: begin wmask = DW'(mode_mask(int'(port))); rval = mode_q[port]; end
      RK_DIR:  begin wmask = DW'(out_mask(int'(port)));  rval = dir_q[port];  end
      RK_PIN:  begin wmask = '0;                         rval = pin_q[port];  end
      RK_SELA: begin wmask = DW'(SELA_MASK);             rval = sela_q;       end
      RK_SELB: begin wmask = DW'(SELB_MASK);             rval = selb_q;       end
      default: ;
    endcase
  end

  // whole-write refusal: a single forbidden bit kills the access
  assign wr_ok  = mapped && (kind != RK_PIN) && ((wdata_i & ~wmask) == '0);
  assign commit = req_i && we_i && wr_ok;

  assign err_o   = req_i && (we_i ? !wr_ok : !mapped);
  assign rdata_o = (req_i && !we_i && mapped) ? rval : '0;

  for (genvar g = 0; g < int'(NPORTS); g++) begin : g_port
    logic hit;
    assign hit = commit && (port == PW'(g));

    gpio_byte_reg #(.W(DW), .RST('0)) u_out (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .we_i  (hit && kind == RK_OUT),
      .d_i   (wdata_i), .q_o (out_q[g])
    );

    gpio_byte_reg #(.W(DW), .RST(DW'(mode_rst(g)))) u_mode (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .we_i  (hit && kind == RK_MODE),
      .d_i   (wdata_i), .q_o (mode_q[g])
    );

    gpio_byte_reg #(.W(DW), .RST('0)) u_dir (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .we_i  (hit && kind == RK_DIR),
      .d_i   (wdata_i), .q_o (dir_q[g])
    );

    gpio_pin_sync #(.W(DW)) u_sync (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .d_i   (pins_i[g*DW +: DW]),
      .q_o   (pin_q[g])
    );

    assign out_o[g*DW +: DW] = out_q[g];
    assign oe_o[g*DW +: DW]  = dir_q[g];
  end

  gpio_byte_reg #(.W(DW), .RST('0)) u_sela (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .we_i  (commit && kind == RK_SELA),
    .d_i   (wdata_i), .q_o (sela_q)
  );

  gpio_byte_reg #(.W(DW), .RST(DW'(SELB_RST))) u_selb (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .we_i  (commit && kind == RK_SELB),
    .d_i   (wdata_i), .q_o (selb_q)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [1:0]           size_i,
  input logic [AW-1:0]        addr_i,
  input logic [DW-1:0]        wdata_i,
  input logic [DW-1:0]        rdata_o,
  input logic                 err_o,
  input logic [NPORTS*DW-1:0] out_o,
  input logic [NPORTS*DW-1:0] oe_o
);

  a_r11_err_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !err_o);

  a_r11_err_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && err_o) |-> (rdata_o == '0));

  a_r4_size_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i != 2'b00) |-> err_o);

  a_r8_pin_write_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i >= AW'(8'h80) && addr_i < AW'(8'h90)) |-> err_o);

  a_r3_refused_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && err_o) |=> ($stable(out_o) && $stable(oe_o)));

  if (NPORTS > 3) begin : g_p3
    a_r5_p3_out_wide_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == AW'(8'h05) && wdata_i[DW-1:2] != '0) |-> err_o);

    a_r5_p3_pads_narrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_o[3*DW+2 +: DW-2] == '0) && (oe_o[3*DW+2 +: DW-2] == '0));
  end

endmodule

bind gpio_bank gpio_bank_chk #(.NPORTS(NPORTS), .DW(DW), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .size_i  (size_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .err_o   (err_o),
  .out_o   (out_o),
  .oe_o    (oe_o)
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        req_i = 0;
  logic        we_i = 0;
  logic [1:0]  size_i = 0;
  logic [7:0]  addr_i = 0;
  logic [7:0]  wdata_i = 0;
  logic [7:0]  rdata_o;
  logic        err_o;
  logic [31:0] pins_i = 0;
  logic [31:0] out_o, oe_o;

  always #5 clk_i = ~clk_i;

  gpio_bank u_dut (
    .clk_i, .rst_ni, .req_i, .we_i, .size_i, .addr_i, .wdata_i,
    .rdata_o, .err_o, .pins_i, .out_o, .oe_o
  );

  typedef struct {
    logic [7:0] rd;
    logic       er;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int n_vec = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model of the register contents
  logic [7:0] m_out[4], m_mode[4], m_dir[4], m_pin[4];
  logic [7:0] m_sela, m_selb;

  task automatic model(input logic we, input logic [7:0] a, input logic [1:0] sz,
                       input logic [7:0] d, output logic [7:0] rd, output logic er);
    int k;
    int p;
    logic [7:0] m;
    p = int'({a[2], a[0]});
    k = -1;
    m = 8'h00;
    if (a == 8'h44) k = 4;
    else if (a == 8'h48) k = 5;
    else if ((a & 8'h1A) == 0) begin
      case (a[7:5])
        3'd0: k = 0;
        3'd1: k = 1;
        3'd3: k = 2;
        3'd4: k = 3;
        default: k = -1;
      endcase
    end
    rd = 8'h00;
    er = 1'b0;
    if (k < 0 || sz != 2'b00) er = 1'b1;
    else if (!we) begin
      case (k)
        0: rd = m_out[p];
        1: rd = m_mode[p];
        2: rd = m_dir[p];
        3: rd = m_pin[p];
        4: rd = m_sela;
        default: rd = m_selb;
      endcase
    end else begin
      case (k)
        0, 2: m = (p == 3) ? 8'h03 : 8'hFF;
        1: m = (p < 2) ? 8'h01 : ((p == 2) ? 8'hFF : 8'h03);
        4: m = 8'h03;
        5: m = 8'h0F;
        default: m = 8'h00;
      endcase
      if (k == 3 || (d & ~m) != 0) er = 1'b1;
      else begin
        case (k)
          0: m_out[p] = d;
          1: m_mode[p] = d;
          2: m_dir[p] = d;
          4: m_sela = d;
          default: m_selb = d;
        endcase
      end
    end
  endtask

  task automatic acc(input logic we, input logic [7:0] a, input logic [1:0] sz,
                     input logic [7:0] d, input string tag);
    item_t it;
    @(negedge clk_i);
    req_i = 1; we_i = we; addr_i = a; size_i = sz; wdata_i = d;
    model(we, a, sz, d, it.rd, it.er);
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic fail_line(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    n_fail++;
    $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
  endtask

  // scoreboard monitor: pops one expected item per strobe cycle
  always @(negedge clk_i) begin
    #2;
    if (req_i && !done) begin
      item_t it;
      n_vec++;
      if (exp_q.size() == 0) fail_line("R11", "unexpected access", 0, 0);
      else begin
        it = exp_q.pop_front();
        if (rdata_o !== it.rd) fail_line(it.tag, "rdata", 32'(rdata_o), 32'(it.rd));
        if (err_o !== it.er)   fail_line(it.tag, "err",   32'(err_o),   32'(it.er));
      end
    end
  end

  task automatic chk_pads(input string tag);
    logic [31:0] eo, ee;
    @(negedge clk_i);
    req_i = 0; we_i = 0; size_i = 0;
    #2;
    eo = {m_out[3], m_out[2], m_out[1], m_out[0]};
    ee = {m_dir[3], m_dir[2], m_dir[1], m_dir[0]};
    n_vec++;
    if (out_o !== eo) fail_line(tag, "out_o", out_o, eo);
    if (oe_o !== ee)  fail_line(tag, "oe_o", oe_o, ee);
    if (err_o !== 1'b0) fail_line("R11", "idle err_o", 32'(err_o), 0);
  endtask

  task automatic read_all(input string tag);
    for (int p = 0; p < 4; p++) begin
      logic [7:0] s;
      s = 8'({p[1], 1'b0, p[0]});
      acc(0, 8'h00 | s, 2'b00, 8'h00, tag);
      acc(0, 8'h20 | s, 2'b00, 8'h00, tag);
      acc(0, 8'h60 | s, 2'b00, 8'h00, tag);
      acc(0, 8'h80 | s, 2'b00, 8'h00, tag);
    end
    acc(0, 8'h44, 2'b00, 8'h00, tag);
    acc(0, 8'h48, 2'b00, 8'h00, tag);
  endtask

  task automatic summary();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    fail_line("R11", "watchdog expired", 0, 0);
    summary();
  end

  initial begin
    for (int p = 0; p < 4; p++) begin
      m_out[p] = 0; m_mode[p] = 0; m_dir[p] = 0; m_pin[p] = 0;
    end
    m_mode[2] = 8'hFF; m_sela = 8'h00; m_selb = 8'h0F;

    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R2: reset contents and pads
    chk_pads("R2");
    read_all("R2");
    chk_pads("R10");

    // R1: legal writes everywhere, read back
    acc(1, 8'h00, 2'b00, 8'hA5, "R1");
    acc(1, 8'h01, 2'b00, 8'h3C, "R1");
    acc(1, 8'h04, 2'b00, 8'hF0, "R1");
    acc(1, 8'h05, 2'b00, 8'h03, "R5");
    acc(1, 8'h20, 2'b00, 8'h01, "R6");
    acc(1, 8'h21, 2'b00, 8'h01, "R6");
    acc(1, 8'h24, 2'b00, 8'h5A, "R1");
    acc(1, 8'h25, 2'b00, 8'h02, "R5");
    acc(1, 8'h60, 2'b00, 8'h0F, "R1");
    acc(1, 8'h61, 2'b00, 8'hFF, "R1");
    acc(1, 8'h64, 2'b00, 8'h81, "R1");
    acc(1, 8'h65, 2'b00, 8'h01, "R5");
    acc(1, 8'h44, 2'b00, 8'h03, "R7");
    acc(1, 8'h48, 2'b00, 8'h0A, "R7");
    read_all("R1");
    chk_pads("R10");

    // R5: port 3 wide writes refused
    acc(1, 8'h05, 2'b00, 8'h04, "R5");
    acc(1, 8'h25, 2'b00, 8'h80, "R5");
    acc(1, 8'h65, 2'b00, 8'hFF, "R5");
    // R6: port 0/1 mode wide writes refused
    acc(1, 8'h20, 2'b00, 8'h02, "R6");
    acc(1, 8'h21, 2'b00, 8'h81, "R6");
    // R7: select masks
    acc(1, 8'h44, 2'b00, 8'h04, "R7");
    acc(1, 8'h48, 2'b00, 8'h10, "R7");
    acc(1, 8'h48, 2'b00, 8'h0F, "R7");
    // R8: pin writes
    acc(1, 8'h80, 2'b00, 8'h00, "R8");
    acc(1, 8'h85, 2'b00, 8'h01, "R8");
    // R3: unmapped offsets, read and write
    acc(1, 8'h02, 2'b00, 8'h11, "R3");
    acc(0, 8'h30, 2'b00, 8'h00, "R3");
    acc(1, 8'h46, 2'b00, 8'h01, "R3");
    acc(0, 8'hFF, 2'b00, 8'h00, "R3");
    acc(1, 8'h86, 2'b00, 8'h00, "R3");
    // R4: non-byte sizes
    acc(1, 8'h00, 2'b01, 8'h00, "R4");
    acc(1, 8'h61, 2'b10, 8'h00, "R4");
    acc(0, 8'h00, 2'b01, 8'h00, "R4");
    acc(0, 8'h24, 2'b10, 8'h00, "R11");
    read_all("R3");
    chk_pads("R5");

    // R9: pin synchronizer latency
    @(negedge clk_i);
    req_i = 0;
    pins_i = 32'h02_C3_7E_81;
    acc(0, 8'h80, 2'b00, 8'h00, "R9");
    m_pin[0] = 8'h81; m_pin[1] = 8'h7E; m_pin[2] = 8'hC3; m_pin[3] = 8'h02;
    acc(0, 8'h80, 2'b00, 8'h00, "R9");
    acc(0, 8'h81, 2'b00, 8'h00, "R9");
    acc(0, 8'h84, 2'b00, 8'h00, "R9");
    acc(0, 8'h85, 2'b00, 8'h00, "R9");
    chk_pads("R9");

    // mixed sweep through model
    for (int i = 0; i < 120; i++) begin
      logic [7:0] al [16];
      al = '{8'h00, 8'h01, 8'h04, 8'h05, 8'h20, 8'h21, 8'h24, 8'h25,
             8'h60, 8'h61, 8'h64, 8'h65, 8'h44, 8'h48, 8'h84, 8'h03};
      acc((i % 3) != 0, al[(i * 7) % 16], ((i % 11) == 5) ? 2'b01 : 2'b00,
          8'((i * 29 + 3) & ((i % 4 == 0) ? 8'hFF : 8'h03)), "R1");
      if ((i % 10) == 9) chk_pads("R10");
    end
    read_all("R1");
    chk_pads("R10");

    repeat (2) @(negedge clk_i);
    if (exp_q.size() != 0) fail_line("R11", "pending items", 32'(exp_q.size()), 0);
    summary();
  end

endmodule